// File: doc/BRIEF.md
# Locked-Entry-Aware Random Replacement Index Generator

This block picks a victim slot for a translation cache refill. Each request steps a 32-bit linear congruential generator and turns the upper half of the new value into an index. The index always falls in the band of slots that software has not locked. Locked slots sit at the bottom of the array, so the band runs from the lock count up to the last populated slot.

The range reduction is a remainder, and the divisor changes at run time. The block works out this remainder one dividend bit per cycle. While it works, busy is high and further requests are dropped. When the remainder is ready, it is offset by the lock count and presented on the index output with a one-cycle valid strobe. If the lock count leaves no free slot, the block skips the division and returns the highest populated slot on the next cycle.

Top module: `rr_victim_picker`

## Requirements
- R1: After reset, the generator state is zero, and valid_o, busy_o and index_o are all 0.
- R2: Each accepted request (req_i high while busy_o is low at a rising edge) replaces the state S with (S * 314159 + 1) mod 2^32. The first request after reset therefore yields state 1.
- R3: Only bits 31 to 16 of the updated state feed index selection. With locked_i = 0 and slots_i = 64, index_o equals bits 21 to 16 of the updated state.
- R4: When locked_i < slots_i, the result is ((state >> 16) mod (slots_i - locked_i)) + locked_i. It therefore lies between locked_i and slots_i - 1. slots_i ranges from 1 to 64.
- R5: When locked_i >= slots_i, the result is slots_i - 1, truncated to 6 bits. valid_o is high in the cycle after the accepting edge, busy_o stays low, and the state still advances.
- R6: In the normal case, busy_o is high for exactly 16 cycles, starting after the accepting edge. valid_o is a one-cycle pulse in the first cycle after busy_o falls, and is never high together with busy_o.
- R7: A request made while busy_o is high is ignored. The state does not advance, and the pending result is neither changed nor delayed.
- R8: A request raised in the same cycle as the valid_o pulse is accepted. index_o keeps the finished result until the new one replaces it.
- R9: locked_i and slots_i are captured at the accepting edge. Changes while busy_o is high do not affect the pending result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 1 | Request strobe for a new victim index |
| locked_i | input | 7 | Number of locked slots at the bottom of the array |
| slots_i | input | 7 | Number of populated slots, 1 to 64 |
| index_o | output | 6 | Chosen slot, held until the next result |
| valid_o | output | 1 | One-cycle strobe marking a fresh index_o |
| busy_o | output | 1 | High while the remainder is being computed |

## Verification
Two events can share a cycle: completion of one computation (the valid_o pulse) and acceptance of the next request. The bench provokes this by raising req_i in exactly the cycle where it sees valid_o high. It then checks three things: index_o still carries the finished value in that cycle, busy_o rises on the following cycle, and the second result matches a generator stepped twice. The bench also drops requests into the busy window with arguments that would otherwise take the immediate no-free-slot path. The pending result must still arrive on schedule, with the value of an unstepped generator.

// File: rtl/rr_pkg.sv
package rr_pkg;

    typedef enum logic [0:0] {
        RD_IDLE = 1'b0,
        RD_RUN  = 1'b1
    } rd_state_e;

    localparam int unsigned RR_SEED_W = 32;
    localparam int unsigned RR_SEL_LO = 16;
    localparam int unsigned RR_MULT   = 314159;

endpackage

// File: rtl/rr_lcg_step.sv
module rr_lcg_step #(
    parameter int unsigned SEED_W = 32,
    parameter int unsigned MULT   = 314159
) (
    input  logic [SEED_W-1:0] cur_i,
    output logic [SEED_W-1:0] nxt_o
);

    localparam logic [SEED_W-1:0] MULT_V = SEED_W'(MULT);
    localparam logic [SEED_W-1:0] INC_V  = SEED_W'(1);

    // Wraps modulo 2^SEED_W by truncation to the operand width.
    always_comb begin
        nxt_o = cur_i * MULT_V + INC_V;
    end

endmodule

// File: rtl/rr_mod_reduce.sv
module rr_mod_reduce
    import rr_pkg::*;
#(
    parameter int unsigned IDX_W = 6,
    parameter int unsigned DIV_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [DIV_W-1:0]     dividend_i,
    input  logic [IDX_W:0]       locked_i,
    input  logic [IDX_W:0]       slots_i,
    output logic [IDX_W-1:0]     index_o,
    output logic                 valid_o,
    output logic                 busy_o
);

    localparam int unsigned CNT_W = IDX_W + 1;
    localparam int unsigned REM_W = CNT_W + 1;
    localparam int unsigned CW    = $clog2(DIV_W);
    localparam logic [CW-1:0] LAST = CW'(DIV_W - 1);

    typedef struct packed {
        rd_state_e          st;
        logic [CW-1:0]      cnt;
        logic [DIV_W-1:0]   dvd;
        logic [REM_W-1:0]   rem;
        logic [CNT_W-1:0]   dvs;
        logic [CNT_W-1:0]   base;
        logic [CNT_W-1:0]   lim;
        logic               deg;
        logic [IDX_W-1:0]   idx;
        logic               vld;
    } red_t;

    red_t red_d, red_q;

    logic [REM_W-1:0] shifted;
    logic [REM_W-1:0] rem_new;
    logic [REM_W-1:0] sum_w;
    logic [CNT_W-1:0] lim_m1;

    always_comb begin
        red_d   = red_q;
        red_d.vld = 1'b0;
        shifted = {red_q.rem[CNT_W-1:0], red_q.dvd[DIV_W-1]};
        if (shifted >= {1'b0, red_q.dvs}) begin
            rem_new = shifted - {1'b0, red_q.dvs};
        end else begin
            rem_new = shifted;
        end
        sum_w  = rem_new + {1'b0, red_q.base};
        lim_m1 = slots_i - CNT_W'(1);

        case (red_q.st)
            RD_IDLE: begin
                if (start_i) begin
                    red_d.base = locked_i;
                    red_d.lim  = slots_i;
                    if (locked_i >= slots_i) begin
                        red_d.deg = 1'b1;
                        red_d.idx = lim_m1[IDX_W-1:0];
                        red_d.vld = 1'b1;
                    end else begin
                        red_d.deg = 1'b0;
                        red_d.dvs = slots_i - locked_i;
                        red_d.dvd = dividend_i;
                        red_d.rem = '0;
                        red_d.cnt = '0;
                        red_d.st  = RD_RUN;
                    end
                end
            end
            RD_RUN: begin
                red_d.rem = rem_new;
                red_d.dvd = {red_q.dvd[DIV_W-2:0], 1'b0};
                if (red_q.cnt == LAST) begin
                    red_d.st  = RD_IDLE;
                    red_d.idx = sum_w[IDX_W-1:0];
                    red_d.vld = 1'b1;
                end else begin
                    red_d.cnt = red_q.cnt + CW'(1);
                end
            end
            default: red_d.st = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            red_q <= '{st: RD_IDLE, default: '0};
        end else begin
            red_q <= red_d;
        end
    end

    assign index_o = red_q.idx;
    assign valid_o = red_q.vld;
    assign busy_o  = (red_q.st == RD_RUN);

    AST_IDX_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (red_q.vld && !red_q.deg) |-> ((CNT_W'(red_q.idx) >= red_q.base) && (CNT_W'(red_q.idx) < red_q.lim))); // R4

    AST_NO_FREE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (red_q.vld && red_q.deg) |-> (CNT_W'(red_q.idx) == ((red_q.lim - CNT_W'(1)) & CNT_W'((1 << IDX_W) - 1)))); // R5

    AST_BUSY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !valid_o); // R6

    AST_END_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> valid_o); // R6

endmodule

// File: rtl/rr_victim_picker.sv
module rr_victim_picker
    import rr_pkg::*;
#(
    parameter int unsigned IDX_W  = 6,
    parameter int unsigned SEED_W = RR_SEED_W,
    parameter int unsigned SEL_LO = RR_SEL_LO,
    parameter int unsigned MULT   = RR_MULT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [IDX_W:0]   locked_i,
    input  logic [IDX_W:0]   slots_i,
    output logic [IDX_W-1:0] index_o,
    output logic             valid_o,
    output logic             busy_o
);

    localparam int unsigned SEL_W = SEED_W - SEL_LO;

    typedef struct packed {
        logic [SEED_W-1:0] seed;
    } gen_t;

    gen_t gen_d, gen_q;

    logic [SEED_W-1:0] seed_nxt;
    logic              accept;
    logic              busy_w;

    rr_lcg_step #(
        .SEED_W (SEED_W),
        .MULT   (MULT)
    ) lcg_i (
        .cur_i (gen_q.seed),
        .nxt_o (seed_nxt)
    );

    always_comb begin
        accept = req_i && !busy_w;
        gen_d  = gen_q;
        if (accept) begin
            gen_d.seed = seed_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gen_q <= '0;
        end else begin
            gen_q <= gen_d;
        end
    end

    rr_mod_reduce #(
        .IDX_W (IDX_W),
        .DIV_W (SEL_W)
    ) red_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (accept),
        .dividend_i (seed_nxt[SEED_W-1:SEL_LO]),
        .locked_i   (locked_i),
        .slots_i    (slots_i),
        .index_o    (index_o),
        .valid_o    (valid_o),
        .busy_o     (busy_w)
    );

    assign busy_o = busy_w;

    AST_HOLD_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && busy_w) |=> $stable(gen_q.seed)); // R7

    AST_START_REACT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !busy_w) |=> (busy_w || valid_o)); // R8

endmodule

// File: tb/rr_victim_picker_tb_top.sv
`timescale 1ns/1ps
module rr_victim_picker_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_i = 1'b0;
    logic [6:0] locked_i = '0;
    logic [6:0] slots_i = 7'd64;
    logic [5:0] index_o;
    logic       valid_o;
    logic       busy_o;

    int unsigned n_chk = 0;
    int unsigned n_err = 0;
    bit          done = 1'b0;

    logic [31:0] m_seed = '0;
    logic [5:0]  m_exp  = '0;

    always #2.5 clk = ~clk;

    rr_victim_picker dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (req_i),
        .locked_i (locked_i),
        .slots_i  (slots_i),
        .index_o  (index_o),
        .valid_o  (valid_o),
        .busy_o   (busy_o)
    );

    function automatic logic [5:0] model_idx(input logic [31:0] s, input int w, input int e);
        int hi;
        hi = int'(s[31:16]);
        if (w >= e) return 6'((e - 1) & 63);
        return 6'((hi % (e - w)) + w);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drives one request; caller guarantees busy_o is low. Ends at the negedge after the accepting edge.
    task automatic launch(input int w, input int e);
        locked_i = 7'(w);
        slots_i  = 7'(e);
        req_i    = 1'b1;
        @(posedge clk);
        m_seed = m_seed * 32'd314159 + 32'd1;
        m_exp  = model_idx(m_seed, w, e);
        @(negedge clk);
        req_i = 1'b0;
    endtask

    task automatic collect(input bit deg, input string tag);
        if (deg) begin
            chk(valid_o == 1'b1, {tag, " R5 valid"}, valid_o, 1);
            chk(busy_o == 1'b0, {tag, " R5 busy"}, busy_o, 0);
            chk(index_o == m_exp, {tag, " R5 index"}, index_o, m_exp);
        end else begin
            chk(busy_o == 1'b1, {tag, " R6 busy rise"}, busy_o, 1);
            repeat (15) @(posedge clk);
            @(negedge clk);
            chk(busy_o == 1'b1 && valid_o == 1'b0, {tag, " R6 still busy"}, {busy_o, valid_o}, 2);
            @(posedge clk);
            @(negedge clk);
            chk(valid_o == 1'b1 && busy_o == 1'b0, {tag, " R6 valid pulse"}, {busy_o, valid_o}, 1);
            chk(index_o == m_exp, {tag, " R4 index"}, index_o, m_exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(valid_o == 0 && busy_o == 0 && index_o == 0, "R1 reset outputs", {index_o, busy_o, valid_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_first();
        launch(5, 40);
        chk(m_exp == 6'd5, "R2 first state gives offset only", m_exp, 5);
        collect(1'b0, "R2 first");
        @(negedge clk);
        chk(valid_o == 1'b0, "R6 pulse one cycle", valid_o, 0);
    endtask

    task automatic t_full_range();
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            launch(0, 64);
            chk(m_exp == m_seed[21:16], "R3 upper bits select", m_exp, m_seed[21:16]);
            collect(1'b0, "R3 full range");
        end
    endtask

    task automatic t_locked();
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            launch(10, 33);
            collect(1'b0, "R4 locked band");
            chk(index_o >= 10 && index_o <= 32, "R4 inside band", index_o, 10);
        end
    endtask

    task automatic t_no_free();
        @(negedge clk);
        launch(20, 20);
        collect(1'b1, "R5 equal");
        @(negedge clk);
        launch(50, 12);
        collect(1'b1, "R5 above");
        @(negedge clk);
        launch(3, 64);
        collect(1'b0, "R5 state advanced");
    endtask

    task automatic t_busy_ignore();
        @(negedge clk);
        launch(7, 50);
        locked_i = 7'd60;
        slots_i  = 7'd4;
        req_i    = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        req_i = 1'b0;
        chk(busy_o == 1'b1 && valid_o == 1'b0, "R7 no early result", {busy_o, valid_o}, 2);
        repeat (12) @(posedge clk);
        @(negedge clk);
        chk(busy_o == 1'b1 && valid_o == 1'b0, "R7 still busy", {busy_o, valid_o}, 2);
        @(posedge clk);
        @(negedge clk);
        chk(valid_o == 1'b1, "R7 on schedule", valid_o, 1);
        chk(index_o == m_exp, "R7 index unchanged", index_o, m_exp);
        @(negedge clk);
        launch(0, 64);
        collect(1'b0, "R7 state not stepped");
    endtask

    task automatic t_capture();
        @(negedge clk);
        launch(12, 30);
        locked_i = 7'd1;
        slots_i  = 7'd5;
        collect(1'b0, "R9 captured args");
    endtask

    task automatic t_back_to_back();
        logic [5:0] prev;
        @(negedge clk);
        launch(4, 61);
        collect(1'b0, "R8 first");
        prev = m_exp;
        launch(9, 26);
        chk(busy_o == 1'b1, "R8 accepted in valid cycle", busy_o, 1);
        chk(index_o == prev, "R8 index held", index_o, prev);
        collect(1'b0, "R8 second");
    endtask

    initial begin
        t_reset();
        t_first();
        t_full_range();
        t_locked();
        t_no_free();
        t_busy_ignore();
        t_capture();
        t_back_to_back();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule